// File: doc/BRIEF.md
# Immediate Segment Load, Insert and Logic Unit

This unit holds one 64-bit general register and updates it from a 16-bit or 32-bit immediate. Each request names an operation and a target segment: one of four 16-bit quarters or one of two 32-bit halves. Segment numbering treats the leftmost bit as bit 0, so quarter 0 is the most significant sixteen bits of the register.

Three load policies are offered. An arithmetic load sign-extends the immediate into a 32-bit or a 64-bit destination. A logical load places the immediate in its segment and zeroes everything else. An insert rewrites only its segment. The unit also performs AND, OR and XOR of the immediate into a segment, and a test-under-mask on a quarter. Together these set a 2-bit condition code that a following conditional branch can use. A request is taken on a clock edge where `op_valid` is high. The register and the condition code show the result from the next edge on.

Top module: `imm_seg_unit`

## Requirements
- R1: After reset, `gr_q` is all zero and `cc_q` is 0.
- R2: Segment codes on `op_seg` are 0 = bits 63:48, 1 = bits 47:32, 2 = bits 31:16, 3 = bits 15:0 (quarters, using `op_imm[15:0]`), 4 = bits 63:32 and 5 = bits 31:0 (halves, using `op_imm[31:0]`). A logical load (`op_code` 1) writes the immediate into that segment and clears every other bit. The result is visible on `gr_q` after the clock edge that accepts the request.
- R3: An insert (`op_code` 2) on any segment replaces only that segment and keeps all other bits.
- R4: An arithmetic load (`op_code` 0) takes a 16-bit source with segment code 3 or a 32-bit source with segment code 5, and sign-extends it. With `op_dst64` = 1 the whole register is written. With `op_dst64` = 0 only bits 31:0 are written and bits 63:32 are kept.
- R5: AND (`op_code` 3) and OR (`op_code` 4) combine the immediate with the chosen quarter or half and leave the rest of the register unchanged.
- R6: XOR (`op_code` 5) combines a 32-bit immediate with a half and leaves the other half unchanged.
- R7: After AND, OR or XOR, `cc_q` is 0 if the resulting segment is all zero, and 1 otherwise.
- R8: Test-under-mask (`op_code` 6) on a quarter uses `op_imm[15:0]` as the mask and leaves `gr_q` unchanged. It sets `cc_q` as follows: 0 if the selected bits are all zero or the mask is zero; 3 if they are all one; 1 if they are mixed and the leftmost selected bit is 0; 2 if they are mixed and that bit is 1.
- R9: The following requests change neither `gr_q` nor `cc_q`: segment codes 6 and 7, `op_code` 7, an arithmetic load with a segment code other than 3 or 5, XOR on a quarter, and test-under-mask on a half.
- R10: Arithmetic loads, logical loads and inserts leave `cc_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request is taken on this edge |
| op_code | input | 3 | Operation (see R2 to R8) |
| op_seg | input | 3 | Target segment code (see R2) |
| op_dst64 | input | 1 | Arithmetic load writes all 64 bits |
| op_imm | input | 32 | Immediate operand |
| gr_q | output | 64 | General register |
| cc_q | output | 2 | Condition code |

## Verification
The immediates are asymmetric, such as 0xA5C3, so that a value landing in the wrong quarter or half shows up at once. Inserts and logic operations run on a register that already holds a distinct pattern in every quarter, which exposes any disturbance outside the target segment. For sign extension, the arithmetic loads use sources with the sign bit set and with it clear, at both destination widths. The test-under-mask masks are chosen to reach each of the four outcomes, including a mixed case with the leftmost selected bit 0 and one with it 1. The invalid combinations are issued with the condition code at a non-zero value, so that a wrongly applied update would be visible on either output.

// File: rtl/imm_seg_pkg.sv
package imm_seg_pkg;
  localparam int GR_W  = 64;
  localparam int Q_W   = GR_W / 4;
  localparam int H_W   = GR_W / 2;
  localparam int N_Q   = GR_W / Q_W;
  localparam int N_H   = GR_W / H_W;
  localparam int CC_W  = 2;

  typedef enum logic [2:0] {
    OP_ALOAD  = 3'd0,
    OP_LLOAD  = 3'd1,
    OP_INSERT = 3'd2,
    OP_AND    = 3'd3,
    OP_OR     = 3'd4,
    OP_XOR    = 3'd5,
    OP_TMASK  = 3'd6,
    OP_RSVD   = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    SG_Q0 = 3'd0,
    SG_Q1 = 3'd1,
    SG_Q2 = 3'd2,
    SG_Q3 = 3'd3,
    SG_HI = 3'd4,
    SG_LO = 3'd5,
    SG_X6 = 3'd6,
    SG_X7 = 3'd7
  } seg_e;

  // sign-extend a quarter-width value to the full register
  function automatic logic [GR_W-1:0] sext_q(input logic [Q_W-1:0] v);
    return {{(GR_W-Q_W){v[Q_W-1]}}, v};
  endfunction

  // sign-extend a half-width value to the full register
  function automatic logic [GR_W-1:0] sext_h(input logic [H_W-1:0] v);
    return {{(GR_W-H_W){v[H_W-1]}}, v};
  endfunction
endpackage

// File: rtl/imm_seg_place.sv
// Decodes the segment code into a field mask and places the immediate
// under that mask.
module imm_seg_place
  import imm_seg_pkg::*;
(
  input  logic [2:0]      seg,
  input  logic [H_W-1:0]  imm,
  output logic [GR_W-1:0] fmask,
  output logic [GR_W-1:0] fdata,
  output logic            is_q,
  output logic            is_h
);
  localparam logic [GR_W-1:0] Q_ONES = {{(GR_W-Q_W){1'b0}}, {Q_W{1'b1}}};
  localparam logic [GR_W-1:0] H_ONES = {{(GR_W-H_W){1'b0}}, {H_W{1'b1}}};

  logic [GR_W-1:0] qm [N_Q];
  logic [GR_W-1:0] hm [N_H];

  for (genvar q = 0; q < N_Q; q++) begin : g_q
    assign qm[q] = (seg == 3'(q)) ? (Q_ONES << ((N_Q-1-q)*Q_W)) : '0;
  end
  for (genvar h = 0; h < N_H; h++) begin : g_h
    assign hm[h] = (seg == 3'(N_Q+h)) ? (H_ONES << ((N_H-1-h)*H_W)) : '0;
  end

  always_comb begin
    fmask = '0;
    for (int q = 0; q < N_Q; q++) fmask |= qm[q];
    for (int h = 0; h < N_H; h++) fmask |= hm[h];
  end

  assign is_q  = (seg < 3'(N_Q));
  assign is_h  = (seg >= 3'(N_Q)) && (seg < 3'(N_Q+N_H));
  assign fdata = is_h ? ({N_H{imm}} & fmask) : ({N_Q{imm[Q_W-1:0]}} & fmask);
endmodule

// File: rtl/imm_seg_tm.sv
// Test-under-mask on one quarter of the register.
module imm_seg_tm
  import imm_seg_pkg::*;
(
  input  logic [GR_W-1:0] gr,
  input  logic [1:0]      qsel,
  input  logic [Q_W-1:0]  mask,
  output logic [CC_W-1:0] tm_cc
);
  logic [Q_W-1:0] qv;
  logic [Q_W-1:0] sel;
  logic           lead_one;

  assign qv  = gr[(GR_W-1) - int'(qsel)*Q_W -: Q_W];
  assign sel = qv & mask;

  // bit of the quarter at the leftmost set position of the mask
  function automatic logic lead_bit(input logic [Q_W-1:0] m,
                                    input logic [Q_W-1:0] v);
    logic found;
    logic b;
    found = 1'b0;
    b     = 1'b0;
    for (int i = Q_W-1; i >= 0; i--) begin
      if (!found && m[i]) begin
        found = 1'b1;
        b     = v[i];
      end
    end
    return b;
  endfunction

  assign lead_one = lead_bit(mask, qv);

  always_comb begin
    if (sel == '0)        tm_cc = 2'd0;
    else if (sel == mask) tm_cc = 2'd3;
    else if (lead_one)    tm_cc = 2'd2;
    else                  tm_cc = 2'd1;
  end
endmodule

// File: rtl/imm_seg_alu.sv
// Next-state logic for the register and the condition code.
module imm_seg_alu
  import imm_seg_pkg::*;
(
  input  logic [2:0]      op,
  input  logic [2:0]      seg,
  input  logic            dst64,
  input  logic [H_W-1:0]  imm,
  input  logic [GR_W-1:0] gr,
  input  logic [GR_W-1:0] fmask,
  input  logic [GR_W-1:0] fdata,
  input  logic            is_q,
  input  logic            is_h,
  input  logic [CC_W-1:0] tm_cc,
  output logic            legal,
  output logic            wr_gr,
  output logic            wr_cc,
  output logic [GR_W-1:0] nxt_gr,
  output logic [CC_W-1:0] nxt_cc
);
  op_e             opc;
  logic [GR_W-1:0] asrc;
  logic [GR_W-1:0] lres;

  assign opc  = op_e'(op);
  assign asrc = (seg == SG_Q3) ? sext_q(imm[Q_W-1:0]) : sext_h(imm);

  always_comb begin
    legal  = 1'b0;
    wr_gr  = 1'b0;
    wr_cc  = 1'b0;
    nxt_gr = gr;
    lres   = gr;
    case (opc)
      OP_ALOAD: begin
        legal  = (seg == SG_Q3) || (seg == SG_LO);
        wr_gr  = legal;
        nxt_gr = dst64 ? asrc : {gr[GR_W-1:H_W], asrc[H_W-1:0]};
      end
      OP_LLOAD: begin
        legal  = is_q || is_h;
        wr_gr  = legal;
        nxt_gr = fdata;
      end
      OP_INSERT: begin
        legal  = is_q || is_h;
        wr_gr  = legal;
        nxt_gr = (gr & ~fmask) | fdata;
      end
      OP_AND: begin
        legal = is_q || is_h;
        lres  = gr & (fdata | ~fmask);
      end
      OP_OR: begin
        legal = is_q || is_h;
        lres  = gr | fdata;
      end
      OP_XOR: begin
        legal = is_h;
        lres  = gr ^ fdata;
      end
      OP_TMASK: begin
        legal = is_q;
        wr_cc = legal;
      end
      default: legal = 1'b0;
    endcase
    if (opc == OP_AND || opc == OP_OR || opc == OP_XOR) begin
      wr_gr  = legal;
      wr_cc  = legal;
      nxt_gr = lres;
    end
  end

  always_comb begin
    if (opc == OP_TMASK) nxt_cc = tm_cc;
    else                 nxt_cc = ((lres & fmask) != '0) ? 2'd1 : 2'd0;
  end
endmodule

// File: rtl/imm_seg_unit.sv
module imm_seg_unit
  import imm_seg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [2:0]  op_code,
  input  logic [2:0]  op_seg,
  input  logic        op_dst64,
  input  logic [31:0] op_imm,
  output logic [63:0] gr_q,
  output logic [1:0]  cc_q
);
  logic [GR_W-1:0] fmask;
  logic [GR_W-1:0] fdata;
  logic            is_q;
  logic            is_h;
  logic [CC_W-1:0] tm_cc;
  logic            legal;
  logic            wr_gr;
  logic            wr_cc;
  logic [GR_W-1:0] nxt_gr;
  logic [CC_W-1:0] nxt_cc;

  imm_seg_place u_place (
    .seg  (op_seg),
    .imm  (op_imm),
    .fmask(fmask),
    .fdata(fdata),
    .is_q (is_q),
    .is_h (is_h)
  );

  imm_seg_tm u_tm (
    .gr   (gr_q),
    .qsel (op_seg[1:0]),
    .mask (op_imm[Q_W-1:0]),
    .tm_cc(tm_cc)
  );

  imm_seg_alu u_alu (
    .op    (op_code),
    .seg   (op_seg),
    .dst64 (op_dst64),
    .imm   (op_imm),
    .gr    (gr_q),
    .fmask (fmask),
    .fdata (fdata),
    .is_q  (is_q),
    .is_h  (is_h),
    .tm_cc (tm_cc),
    .legal (legal),
    .wr_gr (wr_gr),
    .wr_cc (wr_cc),
    .nxt_gr(nxt_gr),
    .nxt_cc(nxt_cc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gr_q <= '0;
      cc_q <= '0;
    end else if (op_valid) begin
      if (wr_gr) gr_q <= nxt_gr;
      if (wr_cc) cc_q <= nxt_cc;
    end
  end
endmodule

// File: rtl/imm_seg_chk.sv
module imm_seg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  op_code,
  input logic        op_dst64,
  input logic        legal,
  input logic [63:0] fmask,
  input logic [63:0] gr_q,
  input logic [1:0]  cc_q
);
  // R2: a logical load leaves nothing set outside its field
  a_r2_lload_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd1 && legal) |=> ((gr_q & ~$past(fmask)) == '0));

  // R3: an insert disturbs no bit outside its field
  a_r3_insert_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd2 && legal) |=>
      (((gr_q ^ $past(gr_q)) & ~$past(fmask)) == '0));

  // R4: a 32-bit arithmetic destination keeps the upper half
  a_r4_dst32_high: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd0 && legal && !op_dst64) |=>
      (gr_q[63:32] == $past(gr_q[63:32])));

  // R7: logic operations only report 0 or 1
  a_r7_logic_cc: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && legal && (op_code == 3'd3 || op_code == 3'd4 || op_code == 3'd5))
      |=> (cc_q[1] == 1'b0));

  // R8: test-under-mask never writes the register
  a_r8_tm_keeps_gr: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd6) |=> $stable(gr_q));

  // R9: rejected requests have no effect
  a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !legal) |=> ($stable(gr_q) && $stable(cc_q)));

  // R10: loads and inserts keep the condition code
  a_r10_load_cc: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code <= 3'd2) |=> $stable(cc_q));

  // R1: nothing moves without a request
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid) |=> ($stable(gr_q) && $stable(cc_q)));
endmodule

bind imm_seg_unit imm_seg_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .op_valid(op_valid),
  .op_code (op_code),
  .op_dst64(op_dst64),
  .legal   (legal),
  .fmask   (fmask),
  .gr_q    (gr_q),
  .cc_q    (cc_q)
);

// File: tb/imm_seg_unit_bench.sv
`timescale 1ns/1ps
module imm_seg_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [2:0]  op_seg = '0;
  logic        op_dst64 = 1'b0;
  logic [31:0] op_imm = '0;
  logic [63:0] gr_q;
  logic [1:0]  cc_q;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  imm_seg_unit u_imm_seg_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_seg(op_seg), .op_dst64(op_dst64), .op_imm(op_imm),
    .gr_q(gr_q), .cc_q(cc_q)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      bad = bad + 1;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk_gr(input string req, input logic [63:0] exp);
    total++;
    if (gr_q !== exp) begin
      bad++;
      $display("FAIL %s gr actual=%h expected=%h", req, gr_q, exp);
    end
  endtask

  task automatic chk_cc(input string req, input logic [1:0] exp);
    total++;
    if (cc_q !== exp) begin
      bad++;
      $display("FAIL %s cc actual=%0d expected=%0d", req, cc_q, exp);
    end
  endtask

  // one request; returns at a falling edge after the result is registered
  task automatic issue(input logic [2:0] op, input logic [2:0] seg,
                       input logic d64, input logic [31:0] imm);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; op_seg = seg; op_dst64 = d64; op_imm = imm;
    @(negedge clk);
    op_valid = 1'b0;
    #1;
  endtask

  task automatic set_pattern();
    issue(3'd2, 3'd4, 1'b0, 32'h0123_4567);
    issue(3'd2, 3'd5, 1'b0, 32'h89AB_CDEF);
  endtask

  task automatic t_reset();
    chk_gr("R1", 64'h0);
    chk_cc("R1", 2'd0);
  endtask

  task automatic t_lload();
    issue(3'd1, 3'd0, 1'b0, 32'h0000_A5C3); chk_gr("R2", 64'hA5C3_0000_0000_0000);
    issue(3'd1, 3'd1, 1'b0, 32'hFFFF_A5C3); chk_gr("R2", 64'h0000_A5C3_0000_0000);
    issue(3'd1, 3'd2, 1'b0, 32'h0000_A5C3); chk_gr("R2", 64'h0000_0000_A5C3_0000);
    issue(3'd1, 3'd3, 1'b0, 32'h0000_A5C3); chk_gr("R2", 64'h0000_0000_0000_A5C3);
    issue(3'd1, 3'd4, 1'b0, 32'h1234_5678); chk_gr("R2", 64'h1234_5678_0000_0000);
    issue(3'd1, 3'd5, 1'b0, 32'h1234_5678); chk_gr("R2", 64'h0000_0000_1234_5678);
  endtask

  task automatic t_insert();
    set_pattern();
    chk_gr("R3", 64'h0123_4567_89AB_CDEF);
    issue(3'd4, 3'd3, 1'b0, 32'h0000_0000);  // OR zero: cc becomes 1
    chk_cc("R7", 2'd1);
    issue(3'd2, 3'd1, 1'b0, 32'h0000_BEEF);
    chk_gr("R3", 64'h0123_BEEF_89AB_CDEF);
    chk_cc("R10", 2'd1);
    issue(3'd2, 3'd3, 1'b0, 32'h0000_1111);
    chk_gr("R3", 64'h0123_BEEF_89AB_1111);
  endtask

  task automatic t_aload();
    set_pattern();
    issue(3'd0, 3'd3, 1'b0, 32'h0000_8001);
    chk_gr("R4", 64'h0123_4567_FFFF_8001);
    issue(3'd0, 3'd3, 1'b1, 32'hFFFF_7FFF);
    chk_gr("R4", 64'h0000_0000_0000_7FFF);
    issue(3'd0, 3'd5, 1'b1, 32'h8000_0000);
    chk_gr("R4", 64'hFFFF_FFFF_8000_0000);
    set_pattern();
    issue(3'd0, 3'd5, 1'b0, 32'h8765_4321);
    chk_gr("R4", 64'h0123_4567_8765_4321);
    chk_cc("R10", 2'd1);
  endtask

  task automatic t_logic();
    set_pattern();
    issue(3'd3, 3'd3, 1'b0, 32'h0000_00F0);
    chk_gr("R5", 64'h0123_4567_89AB_00E0); chk_cc("R7", 2'd1);
    issue(3'd3, 3'd0, 1'b0, 32'h0000_0000);
    chk_gr("R5", 64'h0000_4567_89AB_00E0); chk_cc("R7", 2'd0);
    issue(3'd4, 3'd1, 1'b0, 32'h0000_1000);
    chk_gr("R5", 64'h0000_5567_89AB_00E0); chk_cc("R7", 2'd1);
    issue(3'd3, 3'd4, 1'b0, 32'hFFFF_0000);
    chk_gr("R5", 64'h0000_0000_89AB_00E0); chk_cc("R7", 2'd0);
    issue(3'd5, 3'd5, 1'b0, 32'h89AB_00E0);
    chk_gr("R6", 64'h0000_0000_0000_0000); chk_cc("R7", 2'd0);
    issue(3'd5, 3'd4, 1'b0, 32'hFFFF_AA98);
    chk_gr("R6", 64'hFFFF_AA98_0000_0000); chk_cc("R7", 2'd1);
  endtask

  task automatic t_tmask();
    issue(3'd1, 3'd3, 1'b0, 32'h0000_00F0);
    issue(3'd6, 3'd3, 1'b0, 32'h0000_000F); chk_cc("R8", 2'd0);
    issue(3'd6, 3'd3, 1'b0, 32'h0000_00F0); chk_cc("R8", 2'd3);
    issue(3'd6, 3'd3, 1'b0, 32'h0000_0180); chk_cc("R8", 2'd1);
    issue(3'd6, 3'd3, 1'b0, 32'h0000_0081); chk_cc("R8", 2'd2);
    issue(3'd6, 3'd3, 1'b0, 32'h0000_0000); chk_cc("R8", 2'd0);
    issue(3'd6, 3'd3, 1'b0, 32'h0000_0081);
    issue(3'd6, 3'd0, 1'b0, 32'h0000_FFFF); chk_cc("R8", 2'd0);
    chk_gr("R8", 64'h0000_0000_0000_00F0);
  endtask

  task automatic t_illegal();
    set_pattern();
    issue(3'd6, 3'd3, 1'b0, 32'h0000_00C1);  // 0xCDEF & 0x00C1 = 0x00C1: all ones
    chk_cc("R8", 2'd3);
    issue(3'd5, 3'd2, 1'b0, 32'hFFFF_FFFF);
    chk_gr("R9", 64'h0123_4567_89AB_CDEF); chk_cc("R9", 2'd3);
    issue(3'd6, 3'd5, 1'b0, 32'h0000_0000);
    chk_gr("R9", 64'h0123_4567_89AB_CDEF); chk_cc("R9", 2'd3);
    issue(3'd0, 3'd0, 1'b1, 32'h0000_0001);
    chk_gr("R9", 64'h0123_4567_89AB_CDEF); chk_cc("R9", 2'd3);
    issue(3'd1, 3'd6, 1'b0, 32'h0000_1234);
    chk_gr("R9", 64'h0123_4567_89AB_CDEF); chk_cc("R9", 2'd3);
    issue(3'd3, 3'd7, 1'b0, 32'h0000_0000);
    chk_gr("R9", 64'h0123_4567_89AB_CDEF); chk_cc("R9", 2'd3);
    issue(3'd7, 3'd3, 1'b0, 32'h0000_0000);
    chk_gr("R9", 64'h0123_4567_89AB_CDEF); chk_cc("R9", 2'd3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_lload();
    t_insert();
    t_aload();
    t_logic();
    t_tmask();
    t_illegal();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule